// File: doc/BRIEF.md
# General-Purpose Register File with Indirect Pointer Pairs

This block is the working register file of a small 8-bit RISC core. It holds 32 byte-wide registers. Two independent read ports and a 16-bit view of an even/odd register pair are combinational, so operands are available in the same cycle that the result is computed. A single write port stores either one byte or a full 16-bit pair on the clock edge. Because of this, a fetch, compute and write-back can all complete in one cycle.

The six highest registers form three 16-bit indirect pointers. A pointer port selects one of them, presents an address built from it, and can write an updated value back into the pair. The supported forms are plain, post-increment, pre-decrement and fixed displacement. The register file is also mapped onto the lowest 32 locations of a unified data-space bus. This lets a pointer aimed at a low address read or write another register. Addresses above that window belong to other agents and are not served here.

Every port is a plain control or data pin with no handshake. The file never stalls and never applies back-pressure. Reads are combinational and always valid. Each write is accepted on the clock edge in which its enable is high.

Top module: `gpr_file`

## Requirements
- R1: While reset is active, and right after it is released, every register reads as 0x00.
- R2: The read ports `rd_a_data`/`rd_b_data` show, combinationally, the register chosen by `rd_a_idx`/`rd_b_idx`. `rd_pair_data` shows {odd register, even register} for the pair that contains `rd_a_idx`, with the even register in bits 7:0.
- R3: When `wr_en` is high and `wr_wide` is low, `wr_data[7:0]` is stored into register `wr_idx` at the clock edge. A read of that register in the same cycle returns the old value.
- R4: When `wr_en` and `wr_wide` are both high, both registers of the pair that contains `wr_idx` are written at the same edge. The even index (bit 0 cleared) gets `wr_data[7:0]` and the odd index gets `wr_data[15:8]`, even when `wr_idx` is odd.
- R5: `ptr_sel` chooses the pointer: 0 = registers 26/27, 1 = 28/29, 2 = 30/31, and 3 also means 30/31. The lower register of each pair is the low byte. With `ptr_mode`=1 (post-increment), `ptr_addr` is the current pointer value. When `ptr_en` is high, pointer+1 is written back at the edge.
- R6: With `ptr_mode`=2 (pre-decrement), `ptr_addr` is pointer−1. When `ptr_en` is high, that same value is written back into the pair.
- R7: With `ptr_mode`=0 (plain), `ptr_addr` is the pointer. With `ptr_mode`=3, it is the pointer plus the unsigned 6-bit `ptr_disp`. Neither mode changes the pair. All pointer arithmetic wraps modulo 2^16, so 0xFFFF+1 gives 0x0000 and 0x0000−1 gives 0xFFFF.
- R8: A data-space access (`ds_en`) to an address from 0x0000 to 0x001F addresses the register with that index. `ds_hit` is high, `ds_rdata` returns that register, and when `ds_we` is set `ds_wdata` is stored at the edge.
- R9: A data-space access at 0x0020 or above has no effect. `ds_hit` is low, `ds_rdata` is 0x00, and no register changes.
- R10: When several sources write the same register at one edge, the pointer update wins over the write port, and the write port wins over the data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_data | output | 16 | Pair containing rd_a_idx, odd register in upper byte |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | 1 = write a 16-bit pair, 0 = write one byte |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| ptr_en | input | 1 | Allow the pointer write-back of the selected mode |
| ptr_sel | input | 2 | Pointer select |
| ptr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_disp | input | 6 | Unsigned displacement for mode 3 |
| ptr_addr | output | 16 | Address formed from the selected pointer |
| ds_en | input | 1 | Data-space access strobe |
| ds_we | input | 1 | Data-space write |
| ds_addr | input | 16 | Data-space address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data (0x00 on a miss) |
| ds_hit | output | 1 | Access falls inside the register window |

## Verification
Directed phases run first, followed by a long random phase.

- **Pair writes:** wide writes use both an even and an odd index, so any error in how the pair is formed becomes visible.
- **Pointer wrap:** the pointer modes are driven with values at both wrap edges. This separates the post-increment return-then-update order from the pre-decrement update-then-return order.
- **Same-edge collisions:** one directed step has all three write sources hit the same pointer pair at once, which exposes any mistake in the priority order.
- **Data-space window:** accesses at 0x1F and 0x20 tell the alias window apart from the ignored space.
- **Random phase:** traffic mixes every source and mode, so that read-during-write ordering and the aliasing of pointer registers through the data bus are compared against the model on every cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;

  localparam int unsigned DEF_NREGS    = 32;
  localparam int unsigned DEF_DW       = 8;
  localparam int unsigned DEF_NPTR     = 3;
  localparam int unsigned DEF_PTR_BASE = 26;
  localparam int unsigned DEF_DISPW    = 6;
  localparam int unsigned DEF_AW       = 16;
endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit #(
  parameter int unsigned DW       = gpr_pkg::DEF_DW,
  parameter int unsigned NPTR     = gpr_pkg::DEF_NPTR,
  parameter int unsigned PTR_BASE = gpr_pkg::DEF_PTR_BASE,
  parameter int unsigned DISPW    = gpr_pkg::DEF_DISPW,
  parameter int unsigned IDXW     = 5,
  parameter int unsigned PSELW    = 2
) (
  input  logic [NPTR-1:0][2*DW-1:0] pairs,
  input  logic                      en,
  input  logic [PSELW-1:0]          sel,
  input  logic [1:0]                mode,
  input  logic [DISPW-1:0]          disp,
  output logic [2*DW-1:0]           addr,
  output logic                      upd_en,
  output logic [2*DW-1:0]           upd_val,
  output logic [IDXW-1:0]           upd_lo_idx
);
  import gpr_pkg::*;
  localparam int unsigned PW = 2 * DW;

  logic [PSELW-1:0] eff_sel;
  logic [PW-1:0]    cur;
  logic [PW-1:0]    inc_v;
  logic [PW-1:0]    dec_v;

  always_comb begin
    eff_sel = (int'(sel) >= int'(NPTR)) ? PSELW'(NPTR - 1) : sel;
    cur     = pairs[eff_sel];
    inc_v   = cur + PW'(1);
    dec_v   = cur - PW'(1);
    upd_lo_idx = IDXW'(PTR_BASE + 2 * int'(eff_sel));
    addr    = cur;
    upd_en  = 1'b0;
    upd_val = cur;
    case (ptr_mode_e'(mode))
      PM_POSTINC: begin
        upd_en  = en;
        upd_val = inc_v;
      end
      PM_PREDEC: begin
        addr    = dec_v;
        upd_en  = en;
        upd_val = dec_v;
      end
      PM_DISP: addr = cur + PW'(disp);
      default: addr = cur;
    endcase
  end
endmodule

// File: rtl/gpr_ds_alias.sv
module gpr_ds_alias #(
  parameter int unsigned NREGS = gpr_pkg::DEF_NREGS,
  parameter int unsigned AW    = gpr_pkg::DEF_AW,
  parameter int unsigned IDXW  = 5
) (
  input  logic            ds_en,
  input  logic            ds_we,
  input  logic [AW-1:0]   ds_addr,
  output logic            hit,
  output logic            wr_hit,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    hit    = ds_en && (ds_addr < AW'(NREGS));
    wr_hit = hit && ds_we;
    idx    = ds_addr[IDXW-1:0];
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned NREGS    = gpr_pkg::DEF_NREGS,
  parameter int unsigned DW       = gpr_pkg::DEF_DW,
  parameter int unsigned NPTR     = gpr_pkg::DEF_NPTR,
  parameter int unsigned PTR_BASE = gpr_pkg::DEF_PTR_BASE,
  parameter int unsigned IDXW     = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDXW-1:0]           rd_a_idx,
  output logic [DW-1:0]             rd_a_data,
  input  logic [IDXW-1:0]           rd_b_idx,
  output logic [DW-1:0]             rd_b_data,
  output logic [2*DW-1:0]           rd_pair_data,
  input  logic                      wr_en,
  input  logic                      wr_wide,
  input  logic [IDXW-1:0]           wr_idx,
  input  logic [2*DW-1:0]           wr_data,
  input  logic                      pu_en,
  input  logic [IDXW-1:0]           pu_lo_idx,
  input  logic [2*DW-1:0]           pu_val,
  input  logic                      ds_wr_hit,
  input  logic [IDXW-1:0]           ds_idx,
  input  logic [DW-1:0]             ds_wdata,
  output logic [DW-1:0]             ds_rd,
  output logic [NPTR-1:0][2*DW-1:0] pairs
);
  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [IDXW-1:0] MY = IDXW'(i);
    logic          p_hit;
    logic          w_hit;
    logic          d_hit;
    logic [DW-1:0] p_byte;
    logic [DW-1:0] w_byte;

    always_comb begin
      p_hit  = pu_en && (MY[IDXW-1:1] == pu_lo_idx[IDXW-1:1]);
      p_byte = MY[0] ? pu_val[2*DW-1:DW] : pu_val[DW-1:0];
      w_hit  = wr_en && (wr_wide ? (MY[IDXW-1:1] == wr_idx[IDXW-1:1])
                                 : (MY == wr_idx));
      w_byte = (wr_wide && MY[0]) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
      d_hit  = ds_wr_hit && (ds_idx == MY);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      regs[i] <= '0;
      else if (p_hit)  regs[i] <= p_byte;
      else if (w_hit)  regs[i] <= w_byte;
      else if (d_hit)  regs[i] <= ds_wdata;
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_pair
    assign pairs[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  always_comb begin
    rd_a_data    = regs[rd_a_idx];
    rd_b_data    = regs[rd_b_idx];
    rd_pair_data = {regs[{rd_a_idx[IDXW-1:1], 1'b1}], regs[{rd_a_idx[IDXW-1:1], 1'b0}]};
    ds_rd        = regs[ds_idx];
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NREGS    = gpr_pkg::DEF_NREGS,
  parameter int unsigned DW       = gpr_pkg::DEF_DW,
  parameter int unsigned NPTR     = gpr_pkg::DEF_NPTR,
  parameter int unsigned PTR_BASE = gpr_pkg::DEF_PTR_BASE,
  parameter int unsigned DISPW    = gpr_pkg::DEF_DISPW,
  parameter int unsigned AW       = gpr_pkg::DEF_AW,
  localparam int unsigned IDXW    = $clog2(NREGS),
  localparam int unsigned PSELW   = (NPTR > 1) ? $clog2(NPTR) + ((2**$clog2(NPTR) == NPTR) ? 0 : 0) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDXW-1:0]   rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDXW-1:0]   rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  output logic [2*DW-1:0]   rd_pair_data,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [2*DW-1:0]   wr_data,
  input  logic              ptr_en,
  input  logic [PSELW-1:0]  ptr_sel,
  input  logic [1:0]        ptr_mode,
  input  logic [DISPW-1:0]  ptr_disp,
  output logic [2*DW-1:0]   ptr_addr,
  input  logic              ds_en,
  input  logic              ds_we,
  input  logic [AW-1:0]     ds_addr,
  input  logic [DW-1:0]     ds_wdata,
  output logic [DW-1:0]     ds_rdata,
  output logic              ds_hit
);
  logic [NPTR-1:0][2*DW-1:0] pairs;
  logic                      pu_en;
  logic [2*DW-1:0]           pu_val;
  logic [IDXW-1:0]           pu_lo_idx;
  logic                      ds_wr_hit;
  logic [IDXW-1:0]           ds_idx;
  logic [DW-1:0]             ds_rd;

  gpr_ptr_unit #(
    .DW(DW), .NPTR(NPTR), .PTR_BASE(PTR_BASE), .DISPW(DISPW),
    .IDXW(IDXW), .PSELW(PSELW)
  ) u_ptr (
    .pairs(pairs), .en(ptr_en), .sel(ptr_sel), .mode(ptr_mode),
    .disp(ptr_disp), .addr(ptr_addr), .upd_en(pu_en),
    .upd_val(pu_val), .upd_lo_idx(pu_lo_idx)
  );

  gpr_ds_alias #(.NREGS(NREGS), .AW(AW), .IDXW(IDXW)) u_alias (
    .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr),
    .hit(ds_hit), .wr_hit(ds_wr_hit), .idx(ds_idx)
  );

  gpr_bank #(
    .NREGS(NREGS), .DW(DW), .NPTR(NPTR), .PTR_BASE(PTR_BASE), .IDXW(IDXW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rd_pair_data(rd_pair_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
    .pu_en(pu_en), .pu_lo_idx(pu_lo_idx), .pu_val(pu_val),
    .ds_wr_hit(ds_wr_hit), .ds_idx(ds_idx), .ds_wdata(ds_wdata),
    .ds_rd(ds_rd), .pairs(pairs)
  );

  assign ds_rdata = ds_hit ? ds_rd : '0;
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned AW    = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  rd_a_idx,
  input logic [7:0]  rd_a_data,
  input logic [4:0]  rd_b_idx,
  input logic [7:0]  rd_b_data,
  input logic [15:0] rd_pair_data,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [4:0]  wr_idx,
  input logic [15:0] wr_data,
  input logic        ptr_en,
  input logic [1:0]  ptr_sel,
  input logic [1:0]  ptr_mode,
  input logic [5:0]  ptr_disp,
  input logic [15:0] ptr_addr,
  input logic        ds_en,
  input logic        ds_we,
  input logic [15:0] ds_addr,
  input logic [7:0]  ds_wdata,
  input logic [7:0]  ds_rdata,
  input logic        ds_hit
);
  logic quiet_wr;
  assign quiet_wr = !wr_en && !(ds_en && ds_we);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_a_data == 8'h00 && rd_b_data == 8'h00 && rd_pair_data == 16'h0000));

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && !ptr_en && !(ds_en && ds_we)) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data[7:0])));

  assert_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_mode == 2'd1 && quiet_wr) |=>
      (ptr_sel != $past(ptr_sel) || ptr_mode != 2'd0 || ptr_addr == $past(ptr_addr) + 16'd1));

  assert_predec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_mode == 2'd2 && quiet_wr) |=>
      (ptr_sel != $past(ptr_sel) || ptr_mode != 2'd0 || ptr_addr == $past(ptr_addr)));

  assert_alias_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_en && ds_addr < AW'(NREGS) && rd_b_idx == ds_addr[4:0]) |->
      (ds_hit && ds_rdata == rd_b_data));

  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_en || ds_addr >= AW'(NREGS)) |-> (!ds_hit && ds_rdata == 8'h00));
endmodule

bind gpr_file gpr_file_chk u_chk (.*);

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, ds_wdata, ds_rdata;
  logic [15:0] rd_pair_data, wr_data, ptr_addr, ds_addr;
  logic        wr_en, wr_wide, ptr_en, ds_en, ds_we, ds_hit;
  logic [1:0]  ptr_sel, ptr_mode;
  logic [5:0]  ptr_disp;

  int vectors = 0;
  int errors  = 0;
  int model [32];

  always #2.5 clk = ~clk;

  gpr_file u_dut (.*);

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic int pidx(input logic [1:0] s);
    return (s == 2'd3) ? 2 : int'(s);
  endfunction

  function automatic int pval(input int p);
    return (model[27 + 2*p] << 8) | model[26 + 2*p];
  endfunction

  task automatic quiet();
    wr_en = 0; wr_wide = 0; ptr_en = 0; ds_en = 0; ds_we = 0;
    ptr_mode = 2'd0; ptr_disp = '0; ds_wdata = '0;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Check all outputs against the model, then advance the model over the edge.
  task automatic step(input string tag);
    int cur, e_addr, e_ds, nv, lo;
    int nx [32];
    #1;
    vectors++;
    cur = pval(pidx(ptr_sel));
    case (ptr_mode)
      2'd1: e_addr = cur;
      2'd2: e_addr = (cur - 1) & 16'hFFFF;
      2'd3: e_addr = (cur + int'(ptr_disp)) & 16'hFFFF;
      default: e_addr = cur;
    endcase
    e_ds = (ds_en && ds_addr < 16'd32) ? model[ds_addr[4:0]] : 0;
    cmp(tag, "rd_a", int'(rd_a_data), model[rd_a_idx]);
    cmp(tag, "rd_b", int'(rd_b_data), model[rd_b_idx]);
    cmp(tag, "rd_pair", int'(rd_pair_data),
        (model[rd_a_idx | 5'd1] << 8) | model[rd_a_idx & 5'h1E]);
    cmp(tag, "ptr_addr", int'(ptr_addr), e_addr);
    cmp(tag, "ds_rdata", int'(ds_rdata), e_ds);
    cmp(tag, "ds_hit", int'(ds_hit), int'(ds_en && ds_addr < 16'd32));
    nx = model;
    if (rst_n) begin
      if (ds_en && ds_we && ds_addr < 16'd32) nx[ds_addr[4:0]] = int'(ds_wdata);
      if (wr_en) begin
        if (wr_wide) begin
          nx[wr_idx & 5'h1E] = int'(wr_data[7:0]);
          nx[wr_idx | 5'd1]  = int'(wr_data[15:8]);
        end else nx[wr_idx] = int'(wr_data[7:0]);
      end
      if (ptr_en && (ptr_mode == 2'd1 || ptr_mode == 2'd2)) begin
        nv = (ptr_mode == 2'd1) ? (cur + 1) & 16'hFFFF : (cur - 1) & 16'hFFFF;
        lo = 26 + 2 * pidx(ptr_sel);
        nx[lo]     = nv & 8'hFF;
        nx[lo + 1] = (nv >> 8) & 8'hFF;
      end
    end else begin
      foreach (nx[k]) nx[k] = 0;
    end
    model = nx;
    @(negedge clk);
  endtask

  task automatic wr16(input logic [4:0] idx, input logic [15:0] d, input string tag);
    quiet(); wr_en = 1; wr_wide = 1; wr_idx = idx; wr_data = d; step(tag);
  endtask

  task automatic ptr_op(input logic [1:0] s, input logic [1:0] m, input logic en, input string tag);
    quiet(); ptr_sel = s; ptr_mode = m; ptr_en = en; step(tag);
  endtask

  initial begin
    foreach (model[k]) model[k] = 0;
    rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
    ds_addr = 0; ptr_sel = 0;
    quiet();
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      rd_a_idx = 5'(c * 9); rd_b_idx = 5'(31 - c);
      step("R1 reset");
    end
    rst_n = 1;
    for (int k = 0; k < 32; k++) begin
      quiet(); rd_a_idx = 5'(k); rd_b_idx = 5'(31 - k); step("R1 after reset");
    end

    // Wide writes, even and odd index
    wr16(5'd26, 16'h1234, "R4 even idx");
    wr16(5'd29, 16'hFFFF, "R4 odd idx");
    wr16(5'd30, 16'h0000, "R4 pair Z");
    wr16(5'd3,  16'hBEEF, "R4 low pair");
    quiet(); rd_a_idx = 5'd27; rd_b_idx = 5'd26; step("R2 read X bytes");
    quiet(); rd_a_idx = 5'd2;  rd_b_idx = 5'd3;  step("R2 pair read");

    // Byte write with same-cycle read
    quiet(); wr_en = 1; wr_idx = 5'd5; wr_data = 16'h77AA; rd_a_idx = 5'd5; step("R3 old value");
    quiet(); rd_a_idx = 5'd5; step("R3 new value");

    // Pointer modes
    ptr_op(2'd0, 2'd1, 1'b1, "R5 postinc X");
    ptr_op(2'd0, 2'd0, 1'b0, "R5 X after inc");
    ptr_op(2'd1, 2'd1, 1'b1, "R7 postinc wrap Y");
    ptr_op(2'd1, 2'd0, 1'b0, "R7 Y wrapped");
    ptr_op(2'd2, 2'd2, 1'b1, "R6 predec wrap Z");
    ptr_op(2'd3, 2'd0, 1'b0, "R5 sel3 is Z");
    ptr_op(2'd2, 2'd2, 1'b0, "R6 predec no en");
    ptr_op(2'd2, 2'd0, 1'b0, "R6 unchanged");
    quiet(); ptr_sel = 2'd0; ptr_mode = 2'd3; ptr_disp = 6'd63; ptr_en = 1; step("R7 displacement");
    ptr_op(2'd0, 2'd0, 1'b1, "R7 plain no update");
    ptr_op(2'd0, 2'd0, 1'b0, "R7 X kept");

    // Data-space window
    quiet(); ds_en = 1; ds_addr = 16'h001A; rd_b_idx = 5'd26; step("R8 alias read");
    quiet(); ds_en = 1; ds_we = 1; ds_addr = 16'h001F; ds_wdata = 8'h5C; step("R8 alias write");
    quiet(); rd_a_idx = 5'd31; step("R8 alias written");
    quiet(); ds_en = 1; ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'hE1; step("R9 miss 0x20");
    quiet(); ds_en = 1; ds_we = 1; ds_addr = 16'h0000 | 16'h8003; ds_wdata = 8'h11; step("R9 miss high");
    for (int k = 0; k < 32; k++) begin
      quiet(); rd_a_idx = 5'(k); rd_b_idx = 5'(k ^ 1); step("R9 no register touched");
    end

    // Three writers on the same pair
    quiet(); ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd1;
    wr_en = 1; wr_wide = 0; wr_idx = 5'd26; wr_data = 16'h00C3;
    ds_en = 1; ds_we = 1; ds_addr = 16'h001B; ds_wdata = 8'h9D;
    step("R10 pointer wins");
    quiet(); rd_a_idx = 5'd26; step("R10 result");
    quiet(); wr_en = 1; wr_idx = 5'd8; wr_data = 16'h0042;
    ds_en = 1; ds_we = 1; ds_addr = 16'h0008; ds_wdata = 8'h24; rd_a_idx = 5'd8;
    step("R10 port over bus");
    quiet(); rd_a_idx = 5'd8; step("R10 port result");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom);
      wr_en = 1'($urandom); wr_wide = 1'($urandom);
      wr_idx = ($urandom_range(0, 3) == 0) ? 5'(24 + $urandom_range(0, 7)) : 5'($urandom);
      wr_data = 16'($urandom);
      ptr_en = 1'($urandom); ptr_sel = 2'($urandom); ptr_mode = 2'($urandom);
      ptr_disp = 6'($urandom);
      ds_en = 1'($urandom); ds_we = 1'($urandom);
      ds_addr = ($urandom_range(0, 4) == 0) ? 16'($urandom) : 16'($urandom_range(0, 63));
      ds_wdata = 8'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule